// File: doc/BRIEF.md
# Receiver Reset Handshake Sequencer

This block is the state controller that owns the analog and digital reset lines of one serial receiver channel. After a system reset it holds both resets until receiver calibration is no longer busy. It then steps through an acknowledged release of the analog reset. The digital reset is released only once the clock-data-recovery lock indication has been stable for a programmable minimum time. The same sequence can be started again during operation with a one-cycle request.

The analog reset is released only after the reset-handling logic confirms the assertion by raising an acknowledge. The sequencer then waits for that acknowledge to drop, which confirms the release. Only after that does it start timing the lock indication. Calibration busy, the acknowledge and the lock flag come from another clock domain, so each one passes through a two-flop synchronizer first. A loss of lock during operation puts the channel back into digital reset until lock has again been held long enough. A ready flag follows the digital reset release one cycle later.

Top module: `rx_rst_seq`

## Requirements
- R1: While `rst_n` is sampled low, `ana_rst_o` and `dig_rst_o` are 1 on the next cycle and `ready_o` is 0.
- R2: After reset, both resets stay asserted for as long as `cal_busy_i` is high, whatever the value of `ana_ack_i`.
- R3: Once calibration is idle, `ana_rst_o` stays 1 until `ana_ack_i` is seen high. It falls on the third clock edge after `ana_ack_i` rises: two synchronizer stages plus one state update.
- R4: After the analog release, `dig_rst_o` stays 1 and lock is not timed while `ana_ack_i` remains high. The analog reset is never active while the digital reset is released.
- R5: In the lock-qualification phase, `dig_rst_o` falls only after the synchronized lock has been high for `LOCK_CYCLES` consecutive cycles. Counted from the edge at which the raw `cdr_lock_i` rise is first sampled, `dig_rst_o` is 0 after `LOCK_CYCLES+3` edges and still 1 after `LOCK_CYCLES+2` edges.
- R6: If lock drops during qualification, the elapsed time is discarded, and timing restarts from zero when lock returns.
- R7: `ready_o` equals the inverse of `dig_rst_o` one cycle earlier.
- R8: If lock is lost while the digital reset is released, `dig_rst_o` returns to 1 (with `ana_rst_o` staying 0) and the lock must be requalified.
- R9: A high `reset_req_i` at any point after reset asserts both resets on the next cycle. The full handshake then restarts, with no wait for calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_req_i | input | 1 | Request to restart the reset sequence (synchronous) |
| cal_busy_i | input | 1 | Receiver calibration in progress (asynchronous) |
| ana_ack_i | input | 1 | Analog reset acknowledge from reset-handling logic (asynchronous) |
| cdr_lock_i | input | 1 | Clock-data recovery locked to data (asynchronous) |
| ana_rst_o | output | 1 | Analog reset to the receiver, active high |
| dig_rst_o | output | 1 | Digital reset to the receiver, active high |
| ready_o | output | 1 | Channel out of reset and locked |

## Verification
The checker watches several rules on every cycle: the reset values, the request response, the pairing of ready with the digital reset, and the ordering of analog under digital reset. It also checks that the analog release follows a synchronized acknowledge, that any digital release was preceded by an unbroken lock run of the required length, and that a lost lock reasserts the digital reset. Other behaviour only the bench scenarios can show. These are the exact release cycle of the lock qualification, the discarding of a partial lock run after a glitch, the holding of reset during calibration, and the need for a fresh handshake after a mid-operation request.

// File: rtl/rx_rst_pkg.sv
// Package: shared types for the receiver reset sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package rx_rst_pkg;

    // Sequencer states, in order of the normal release sequence
    typedef enum logic [2:0] {
        ST_CAL_WAIT = 3'd0,   // power-up: hold until calibration idle
        ST_ASSERT   = 3'd1,   // both resets on, wait for acknowledge high
        ST_RELEASE  = 3'd2,   // analog released, wait for acknowledge low
        ST_LOCK     = 3'd3,   // qualify lock for the minimum time
        ST_RUN      = 3'd4    // digital reset released
    } seq_state_e;

    // Bit positions of the synchronized input bundle
    localparam int SYNC_CAL  = 0;
    localparam int SYNC_ACK  = 1;
    localparam int SYNC_LOCK = 2;
    localparam int SYNC_W    = 3;

endpackage

// File: rtl/rx_rst_sync.sv
// Module: multi-bit two-flop synchronizer, one independent chain per bit.
// Assumes: bits are unrelated level signals, so no bus coherence is needed.
// Each bit resets to its own value from RST_VAL.
module rx_rst_sync #(
    parameter int          WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        // Two-stage capture of one asynchronous bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[b] <= RST_VAL[b];
                sync_q[b] <= RST_VAL[b];
            end else begin
                meta_q[b] <= async_i[b];
                sync_q[b] <= meta_q[b];
            end
        end
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/rx_rst_lock_timer.sv
// Module: counts consecutive cycles of a held lock flag.
// Assumes: enable_i is high only in the qualification phase. The count
// clears whenever enable or lock is low and saturates at LOCK_CYCLES.
module rx_rst_lock_timer #(
    parameter int LOCK_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic lock_i,
    output logic done_o
);

    localparam int CW = $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(LOCK_CYCLES);

    logic [CW-1:0] cnt_q;

    // Consecutive-lock counter with clear on any break
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable_i || !lock_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = (cnt_q == CNT_MAX);

endmodule

// File: rtl/rx_rst_fsm.sv
// Module: reset sequencing state machine and ready flag.
// Assumes: all level inputs are already synchronized to clk. req_i is a
// synchronous pulse and takes priority over every other transition.
module rx_rst_fsm
    import rx_rst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic cal_s_i,
    input  logic ack_s_i,
    input  logic lock_s_i,
    input  logic lock_done_i,
    output logic timer_en_o,
    output logic ana_rst_o,
    output logic dig_rst_o,
    output logic ready_o
);

    seq_state_e st_q, st_d;
    logic       ready_q;

    // Next-state selection; a request always restarts at assertion
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_CAL_WAIT: if (!cal_s_i)                st_d = ST_ASSERT;
            ST_ASSERT:   if (ack_s_i)                 st_d = ST_RELEASE;
            ST_RELEASE:  if (!ack_s_i)                st_d = ST_LOCK;
            ST_LOCK:     if (lock_s_i && lock_done_i) st_d = ST_RUN;
            ST_RUN:      if (!lock_s_i)               st_d = ST_LOCK;
            default:                                  st_d = ST_CAL_WAIT;
        endcase
        if (req_i) st_d = ST_ASSERT;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_CAL_WAIT;
        else        st_q <= st_d;
    end

    // Ready follows the digital release by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= !dig_rst_o;
    end

    assign ana_rst_o  = (st_q == ST_CAL_WAIT) || (st_q == ST_ASSERT);
    assign dig_rst_o  = (st_q != ST_RUN);
    assign timer_en_o = (st_q == ST_LOCK);
    assign ready_o    = ready_q;

endmodule

// File: rtl/rx_rst_seq.sv
// Module: receiver reset handshake sequencer (top).
// Drives analog/digital reset of one receiver channel: acknowledged analog
// release, then digital release after a minimum held CDR lock.
// Assumes: cal_busy_i, ana_ack_i, cdr_lock_i are asynchronous levels;
// reset_req_i is synchronous to clk. LOCK_CYCLES = minimum lock time in clk
// cycles (default 4 us at 100 MHz).
module rx_rst_seq
    import rx_rst_pkg::*;
#(
    parameter int LOCK_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reset_req_i,
    input  logic cal_busy_i,
    input  logic ana_ack_i,
    input  logic cdr_lock_i,
    output logic ana_rst_o,
    output logic dig_rst_o,
    output logic ready_o
);

    // Calibration resets to busy so power-up never skips the wait
    localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(1) << SYNC_CAL;

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] syn_in;
    logic              ack_s;
    logic              lock_s;
    logic              cal_s;
    logic              timer_en;
    logic              lock_done;

    assign raw_in[SYNC_CAL]  = cal_busy_i;
    assign raw_in[SYNC_ACK]  = ana_ack_i;
    assign raw_in[SYNC_LOCK] = cdr_lock_i;

    rx_rst_sync #(.WIDTH(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn_in)
    );

    assign cal_s  = syn_in[SYNC_CAL];
    assign ack_s  = syn_in[SYNC_ACK];
    assign lock_s = syn_in[SYNC_LOCK];

    rx_rst_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (timer_en),
        .lock_i   (lock_s),
        .done_o   (lock_done)
    );

    rx_rst_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (reset_req_i),
        .cal_s_i     (cal_s),
        .ack_s_i     (ack_s),
        .lock_s_i    (lock_s),
        .lock_done_i (lock_done),
        .timer_en_o  (timer_en),
        .ana_rst_o   (ana_rst_o),
        .dig_rst_o   (dig_rst_o),
        .ready_o     (ready_o)
    );

endmodule

// File: rtl/rx_rst_seq_chk.sv
// Module: assertion checker for rx_rst_seq, attached by bind.
// Assumes: ack_s/lock_s are the synchronizer outputs of the top. It keeps
// its own run-length count of synchronized lock to judge each release.
module rx_rst_seq_chk #(
    parameter int LOCK_CYCLES = 400
) (
    input logic clk,
    input logic rst_n,
    input logic reset_req_i,
    input logic ana_rst_o,
    input logic dig_rst_o,
    input logic ready_o,
    input logic ack_s,
    input logic lock_s
);

    logic [31:0] run_q;

    // Independent count of consecutive synchronized lock cycles
    always_ff @(posedge clk) begin
        if (!rst_n)                           run_q <= '0;
        else if (!lock_s)                     run_q <= '0;
        else if (run_q <= 32'(LOCK_CYCLES))   run_q <= run_q + 1'b1;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (ana_rst_o && dig_rst_o && !ready_o));

    assert_ana_release_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ana_rst_o) |-> $past(ack_s));

    assert_ana_under_dig_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ana_rst_o |-> dig_rst_o);

    assert_dig_release_lock_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dig_rst_o) |-> (run_q >= 32'(LOCK_CYCLES) && !$past(ack_s)));

    assert_ready_follows_dig_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ready_o == !$past(dig_rst_o)));

    assert_lock_loss_reasserts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_s && !dig_rst_o && !reset_req_i) |=> (dig_rst_o && !ana_rst_o));

    assert_request_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_i |=> (ana_rst_o && dig_rst_o));

endmodule

bind rx_rst_seq rx_rst_seq_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reset_req_i (reset_req_i),
    .ana_rst_o   (ana_rst_o),
    .dig_rst_o   (dig_rst_o),
    .ready_o     (ready_o),
    .ack_s       (ack_s),
    .lock_s      (lock_s)
);

// File: tb/rx_rst_seq_tb.sv
// Bench: self-checking test of rx_rst_seq with a short lock time.
module rx_rst_seq_tb;

    localparam int LOCKC = 16;
    localparam int NVEC  = 6;
    // Lock run lengths in edges; release expected from LOCKC+3 edges (R5)
    localparam int RUN_LEN [NVEC] = '{4, 10, LOCKC+1, LOCKC+2, LOCKC+3, 30};
    localparam bit EXP_REL [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reset_req_i = 1'b0;
    logic cal_busy_i = 1'b1;
    logic ana_ack_i = 1'b0;
    logic cdr_lock_i = 1'b0;
    logic ana_rst_o, dig_rst_o, ready_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rx_rst_seq #(.LOCK_CYCLES(LOCKC)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reset_req_i (reset_req_i),
        .cal_busy_i  (cal_busy_i),
        .ana_ack_i   (ana_ack_i),
        .cdr_lock_i  (cdr_lock_i),
        .ana_rst_o   (ana_rst_o),
        .dig_rst_o   (dig_rst_o),
        .ready_o     (ready_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        step(1);
        step(3);
        // R1: reset state
        check("R1 ana_rst in reset", ana_rst_o, 1'b1);
        check("R1 dig_rst in reset", dig_rst_o, 1'b1);
        check("R1 ready in reset",   ready_o,   1'b0);

        // R2: calibration busy holds everything, acknowledge ignored
        rst_n = 1'b1;
        ana_ack_i = 1'b1;
        step(20);
        check("R2 ana_rst held while cal busy", ana_rst_o, 1'b1);
        check("R2 dig_rst held while cal busy", dig_rst_o, 1'b1);
        ana_ack_i = 1'b0;
        step(5);
        cal_busy_i = 1'b0;
        step(20);
        // R3: no acknowledge yet, analog reset stays on
        check("R3 ana_rst held without ack", ana_rst_o, 1'b1);
        ana_ack_i = 1'b1;
        step(2);
        check("R3 ana_rst still on two edges after ack", ana_rst_o, 1'b1);
        step(1);
        check("R3 ana_rst released three edges after ack", ana_rst_o, 1'b0);
        // R4: ack still high, lock present but not qualified
        cdr_lock_i = 1'b1;
        step(LOCKC + 10);
        check("R4 dig_rst held while ack high", dig_rst_o, 1'b1);
        cdr_lock_i = 1'b0;
        ana_ack_i = 1'b0;
        step(5);
        check("R4 dig_rst held after ack low, no lock", dig_rst_o, 1'b1);

        // Table walk: lock run lengths around the qualification limit
        for (int v = 0; v < NVEC; v++) begin
            cdr_lock_i = 1'b1;
            step(RUN_LEN[v]);
            check($sformatf("R5 dig_rst after %0d lock edges", RUN_LEN[v]),
                  dig_rst_o, !EXP_REL[v]);
            step(1);
            check($sformatf("R7 ready after %0d lock edges", RUN_LEN[v]),
                  ready_o, EXP_REL[v]);
            cdr_lock_i = 1'b0;
            step(4);
            check("R8 dig_rst back on after lock loss", dig_rst_o, 1'b1);
            check("R8 ready cleared after lock loss",   ready_o,   1'b0);
            check("R8 ana_rst stays off on lock loss",  ana_rst_o, 1'b0);
        end

        // R6: glitch in lock discards the partial run
        cdr_lock_i = 1'b1;
        step(12);
        cdr_lock_i = 1'b0;
        step(3);
        cdr_lock_i = 1'b1;
        step(LOCKC + 1);
        check("R6 dig_rst held after glitch restart", dig_rst_o, 1'b1);
        step(2);
        check("R6 dig_rst released after full run", dig_rst_o, 1'b0);
        step(2);
        check("R7 ready high in run", ready_o, 1'b1);

        // R9: mid-operation request restarts with a fresh handshake
        reset_req_i = 1'b1;
        step(1);
        reset_req_i = 1'b0;
        check("R9 ana_rst on after request", ana_rst_o, 1'b1);
        check("R9 dig_rst on after request", dig_rst_o, 1'b1);
        step(1);
        check("R9 ready dropped after request", ready_o, 1'b0);
        step(10);
        check("R9 ana_rst waits for new ack", ana_rst_o, 1'b1);
        ana_ack_i = 1'b1;
        step(4);
        check("R9 ana_rst released by new ack", ana_rst_o, 1'b0);
        ana_ack_i = 1'b0;
        step(4);
        check("R9 dig_rst held during requalify", dig_rst_o, 1'b1);
        step(LOCKC + 2);
        check("R9 dig_rst released after requalify", dig_rst_o, 1'b0);

        finished = 1'b1;
        report();
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

endmodule